// File: doc/BRIEF.md
# Banked Program Counter Sequencer

This block is the program-flow unit of a small nibble-wide controller with a 12-bit code address. It owns the program counter, where the top bit picks one of two 2K banks, and a return-address stack. Every cycle it presents one ROM address and reads back one byte. Most cycles fetch an opcode. Some fetch the second byte of a two-byte instruction. A table read fetches one data byte at an address built from the E and AC nibbles.

It executes absolute jumps, page-relative computed jumps, table reads, a one-byte call to fixed slots of the lowest 64 bytes, a two-byte call into bank 0, subroutine return, and interrupt return. Interrupt return also hands the saved carry and zero flags back to the datapath. A one-byte bank-toggle prefix flips the bank bit, but only for a jump that follows it directly.

Top module: `pc_sequencer`

## Requirements
- R1: During and straight after reset the block fetches an opcode from address 0x000, the overflow bit reads 0 and no bank toggle is pending.
- R2: Any opcode not listed in R3 to R10 advances the PC by 1. A two-byte opcode whose second byte is not a control transfer advances it by 2. The PC wraps modulo 4096, so 0xFFF is followed by 0x000. A two-byte opcode spends exactly one cycle fetching its second byte at PC+1.
- R3: Opcode 0110_1abc followed by byte d is a jump. It loads PC[10:0] with {abc,d} and leaves PC[11] unchanged.
- R4: Opcode 0xFD inverts PC[11] for the jump in R3, provided that jump is the very next instruction. If any other opcode comes next, the prefix is dropped and has no effect.
- R5: Opcode 0xFA replaces PC[7:0] with {E,AC} and keeps PC[11:8].
- R6: Opcode 0x63 is a table read and lasts two cycles. The second cycle reads the ROM at {PC[11:8],E,AC} and raises ea_load for one cycle. During that cycle, E receives byte[7:4] and AC receives byte[3:0]. The PC then advances by 1.
- R7: Opcode 1011_pppp pushes PC+1 and jumps to {6'b0,pppp,2'b00}.
- R8: Opcode 1010_1abc followed by byte d pushes PC+2 and jumps to {1'b0,abc,d}.
- R9: Opcode 0x62 pops the PC. Opcode 0x22 pops the PC and, in its opcode cycle, raises flag_restore with cf_out/zf_out equal to the saved carry and zero inputs.
- R10: The stack holds 8 entries. A push onto a full stack replaces the oldest entry and sets a sticky overflow bit, which only reset clears. Later pops still return the 8 newest entries, newest first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rom_addr | output | 12 | Address of the byte read this cycle |
| rom_data | input | 8 | ROM byte at rom_addr, same cycle |
| insn_fetch | output | 1 | High when rom_addr is an opcode fetch |
| e_in | input | 4 | E nibble from the datapath |
| ac_in | input | 4 | AC nibble from the datapath |
| ea_load | output | 1 | Table-read byte is on e_out/ac_out |
| e_out | output | 4 | Table byte upper nibble |
| ac_out | output | 4 | Table byte lower nibble |
| cf_saved | input | 1 | Saved carry flag copy |
| zf_saved | input | 1 | Saved zero flag copy |
| flag_restore | output | 1 | Interrupt return restores the flags |
| cf_out | output | 1 | Carry value to restore |
| zf_out | output | 1 | Zero value to restore |
| stk_ovf | output | 1 | Sticky return-stack overflow |

## Verification
The assertions rely on three things. First, rom_data must be a pure function of rom_addr that has settled before the sampling edge. Second, E and AC must hold steady across any cycle that forms a page address. Third, reset must be asserted before the first edge. The bench models the ROM as a combinational lookup into a sparse program, keeps E and AC constant for a whole run, and changes programs only while reset is held. The programs use only defined opcodes, and no subroutine return is issued once the stack is empty.

// File: rtl/pc_sequencer.sv
`timescale 1ns/1ps
module pc_sequencer #(
  parameter int STACK_DEPTH = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  output logic [11:0] rom_addr,
  input  logic [7:0]  rom_data,
  output logic        insn_fetch,
  input  logic [3:0]  e_in,
  input  logic [3:0]  ac_in,
  output logic        ea_load,
  output logic [3:0]  e_out,
  output logic [3:0]  ac_out,
  input  logic        cf_saved,
  input  logic        zf_saved,
  output logic        flag_restore,
  output logic        cf_out,
  output logic        zf_out,
  output logic        stk_ovf
);
  localparam int AW  = 12;
  localparam int SPW = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;
  localparam int CW  = $clog2(STACK_DEPTH + 1);

  typedef enum logic [1:0] {ST_OP, ST_ARG, ST_TBL} st_t;

  st_t           st;
  logic [AW-1:0] pc;
  logic [7:0]    op_q;
  logic          bank_pend, flip_q;
  logic [AW-1:0] stk [STACK_DEPTH];
  logic [SPW-1:0] sp;
  logic [CW-1:0]  cnt;

  logic op_c, is_jmp, is_cal, is_czp, is_jpea, is_tbl, is_rt, is_rti, is_bank;
  assign op_c    = (st == ST_OP);
  assign is_jmp  = rom_data[7:3] == 5'b01101;
  assign is_cal  = rom_data[7:3] == 5'b10101;
  assign is_czp  = rom_data[7:4] == 4'b1011;
  assign is_jpea = rom_data == 8'hFA;
  assign is_tbl  = rom_data == 8'h63;
  assign is_rt   = rom_data == 8'h62;
  assign is_rti  = rom_data == 8'h22;
  assign is_bank = rom_data == 8'hFD;

  logic [AW-1:0] pc_p1, pc_p2, page_tgt;
  assign pc_p1    = pc + 12'd1;
  assign pc_p2    = pc + 12'd2;
  assign page_tgt = {pc[11:8], e_in, ac_in};

  logic arg_jmp;
  assign arg_jmp = op_q[7:3] == 5'b01101;

  logic push, pop;
  logic [AW-1:0]  push_val;
  logic [SPW-1:0] sp_inc, sp_dec;
  assign push     = (op_c && is_czp) || (st == ST_ARG && !arg_jmp);
  assign pop      = op_c && (is_rt || is_rti);
  assign push_val = (st == ST_ARG) ? pc_p2 : pc_p1;
  assign sp_inc   = (sp == SPW'(STACK_DEPTH - 1)) ? '0 : sp + 1'b1;
  assign sp_dec   = (sp == '0) ? SPW'(STACK_DEPTH - 1) : sp - 1'b1;

  assign rom_addr     = (st == ST_ARG) ? pc_p1 : (st == ST_TBL) ? page_tgt : pc;
  assign insn_fetch   = op_c;
  assign ea_load      = (st == ST_TBL);
  assign e_out        = rom_data[7:4];
  assign ac_out       = rom_data[3:0];
  assign flag_restore = op_c && is_rti;
  assign cf_out       = cf_saved;
  assign zf_out       = zf_saved;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_OP;
      pc        <= '0;
      op_q      <= '0;
      bank_pend <= 1'b0;
      flip_q    <= 1'b0;
    end else begin
      case (st)
        ST_OP: begin
          bank_pend <= is_bank;
          if (is_jmp || is_cal) begin
            op_q   <= rom_data;
            flip_q <= bank_pend && is_jmp;
            st     <= ST_ARG;
          end else if (is_tbl)  st <= ST_TBL;
          else if (is_jpea)     pc <= page_tgt;
          else if (is_czp)      pc <= {6'b0, rom_data[3:0], 2'b00};
          else if (pop)         pc <= stk[sp_dec];
          else                  pc <= pc_p1;
        end
        ST_ARG: begin
          st <= ST_OP;
          if (arg_jmp) pc <= {pc[11] ^ flip_q, op_q[2:0], rom_data};
          else         pc <= {1'b0, op_q[2:0], rom_data};
        end
        default: begin
          st <= ST_OP;
          pc <= pc_p1;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) stk[sp] <= push_val;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp      <= '0;
      cnt     <= '0;
      stk_ovf <= 1'b0;
    end else if (push) begin
      sp <= sp_inc;
      if (cnt == CW'(STACK_DEPTH)) stk_ovf <= 1'b1;
      else                         cnt <= cnt + 1'b1;
    end else if (pop) begin
      sp <= sp_dec;
      if (cnt != '0) cnt <= cnt - 1'b1;
    end
  end

  assert_arg_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!insn_fetch && !ea_load) |=> insn_fetch) else $error("arg stage too long");
  assert_tbl_two_cycles_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ea_load |=> insn_fetch) else $error("table read length");
  assert_czp_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_fetch && is_czp) |=> (insn_fetch && rom_addr[11:6] == 6'd0 && rom_addr[1:0] == 2'd0))
    else $error("zero-page call target");
  assert_ret_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    flag_restore |=> insn_fetch) else $error("return length");
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    stk_ovf |=> stk_ovf) else $error("overflow not sticky");
  assert_depth_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(STACK_DEPTH)) else $error("stack count out of range");
  assert_bank_oneshot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_pend && insn_fetch && !is_bank) |=> !bank_pend) else $error("bank prefix lingers");
endmodule

// File: tb/pc_sequencer_tb_top.sv
`timescale 1ns/1ps
module pc_sequencer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [11:0] rom_addr;
  logic [7:0]  rom_data;
  logic insn_fetch, ea_load, flag_restore, cf_out, zf_out, stk_ovf;
  logic [3:0] e_in, ac_in, e_out, ac_out;
  logic cf_saved, zf_saved;
  int prog = 0;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pc_sequencer dut_i (
    .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
    .insn_fetch(insn_fetch), .e_in(e_in), .ac_in(ac_in), .ea_load(ea_load),
    .e_out(e_out), .ac_out(ac_out), .cf_saved(cf_saved), .zf_saved(zf_saved),
    .flag_restore(flag_restore), .cf_out(cf_out), .zf_out(zf_out), .stk_ovf(stk_ovf)
  );

  function automatic logic [7:0] rom_fn(input int p, input logic [11:0] a);
    logic [7:0] d = 8'h00;
    if (p == 0) begin
      case (a)
        12'h000: d = 8'h6B; 12'h001: d = 8'h45; 12'h345: d = 8'hFD;
        12'h346: d = 8'h69; 12'h347: d = 8'h10; 12'h910: d = 8'hB5;
        12'h014: d = 8'hA9; 12'h015: d = 8'h23; 12'h123: d = 8'hFA;
        12'h1A5: d = 8'h62; 12'h016: d = 8'h22; 12'h911: d = 8'h63;
        12'h9A5: d = 8'hC7; 12'h912: d = 8'hFD; 12'h913: d = 8'h00;
        12'h914: d = 8'h6A; 12'h915: d = 8'h00; 12'hA00: d = 8'h68;
        12'hA01: d = 8'h00; 12'h800: d = 8'hFD; 12'h801: d = 8'h68;
        12'h802: d = 8'h00;
        default: d = 8'h00;
      endcase
    end else if (p == 1) begin
      if (a == 12'h005) d = 8'h68;
      else if (a == 12'h006) d = 8'h40;
      else if (a == 12'h040) d = 8'h68;
      else if (a == 12'h041) d = 8'h40;
      else if (a <= 12'h020 && a[1:0] == 2'b00) d = {4'b1011, a[5:2] + 4'd1};
      else if (a <= 12'h021 && a[1:0] == 2'b01) d = 8'h62;
      else if (a == 12'h024) d = 8'h62;
    end else begin
      case (a)
        12'h000: d = 8'hFD; 12'h001: d = 8'h6F; 12'h002: d = 8'hFF;
        default: d = 8'h00;
      endcase
    end
    return d;
  endfunction

  always_comb rom_data = rom_fn(prog, rom_addr);

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // {addr, insn_fetch, ea_load, flag_restore} per cycle of program 0
  localparam logic [14:0] MAIN_VEC [23] = '{
    {12'h000, 3'b100}, {12'h001, 3'b000}, {12'h345, 3'b100}, {12'h346, 3'b100},
    {12'h347, 3'b000}, {12'h910, 3'b100}, {12'h014, 3'b100}, {12'h015, 3'b000},
    {12'h123, 3'b100}, {12'h1A5, 3'b100}, {12'h016, 3'b101}, {12'h911, 3'b100},
    {12'h9A5, 3'b010}, {12'h912, 3'b100}, {12'h913, 3'b100}, {12'h914, 3'b100},
    {12'h915, 3'b000}, {12'hA00, 3'b100}, {12'hA01, 3'b000}, {12'h800, 3'b100},
    {12'h801, 3'b100}, {12'h802, 3'b000}, {12'h000, 3'b100}
  };

  task automatic start(input int p);
    rst_n = 1'b0;
    prog = p;
    repeat (3) @(negedge clk);
    chk("R1 reset addr", 32'(rom_addr), 32'h000);
    chk("R1 reset fetch", 32'(insn_fetch), 32'h1);
    chk("R1 reset ovf", 32'(stk_ovf), 32'h0);
    rst_n = 1'b1;
  endtask

  initial begin
    e_in = 4'hA; ac_in = 4'h5; cf_saved = 1'b1; zf_saved = 1'b0;
    start(0);
    // R2 R3 R4 R5 R6 R7 R8 R9 walked by the vector table
    for (int i = 0; i < 23; i++) begin
      chk("R2/R3/R4/R5/R7/R8 addr", 32'(rom_addr), 32'(MAIN_VEC[i][14:3]));
      chk("R2 fetch flag", 32'(insn_fetch), 32'(MAIN_VEC[i][2]));
      chk("R6 ea_load", 32'(ea_load), 32'(MAIN_VEC[i][1]));
      chk("R9 flag_restore", 32'(flag_restore), 32'(MAIN_VEC[i][0]));
      if (MAIN_VEC[i][1]) chk("R6 table byte", 32'({e_out, ac_out}), 32'hC7);
      if (MAIN_VEC[i][0]) chk("R9 flags", 32'({cf_out, zf_out}), 32'b10);
      @(negedge clk);
    end

    // R10: nine nested zero-page calls, then eight returns
    start(1);
    begin
      logic [11:0] exp_seq [19];
      int idx = 0;
      for (int k = 0; k < 9; k++) exp_seq[k] = 12'(4 * k);
      exp_seq[9] = 12'h024;
      for (int j = 0; j < 8; j++) exp_seq[10 + j] = 12'(12'h021 - 4 * j);
      exp_seq[18] = 12'h040;
      for (int c = 0; c < 120 && idx < 19; c++) begin
        if (insn_fetch) begin
          chk("R10 return order", 32'(rom_addr), 32'(exp_seq[idx]));
          if (idx == 8) chk("R10 no ovf at 8", 32'(stk_ovf), 32'h0);
          if (idx == 9) chk("R10 ovf on 9th push", 32'(stk_ovf), 32'h1);
          idx++;
        end
        @(negedge clk);
      end
      chk("R10 sequence complete", 32'(idx), 32'd19);
      chk("R10 ovf sticky", 32'(stk_ovf), 32'h1);
    end

    // R2 wrap at 0xFFF, R4 toggle from bank 0
    start(2);
    begin
      logic [11:0] wexp [4] = '{12'h000, 12'h001, 12'hFFF, 12'h000};
      int idx = 0;
      for (int c = 0; c < 20 && idx < 4; c++) begin
        if (insn_fetch) begin
          chk("R2/R4 wrap sequence", 32'(rom_addr), 32'(wexp[idx]));
          idx++;
        end
        @(negedge clk);
      end
      chk("R2 wrap complete", 32'(idx), 32'd4);
    end

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule